// File: doc/BRIEF.md
# Three-Level Rotating Bus Arbiter

This block picks the next owner of a shared expansion bus. Requests arrive in three top-level groups: a slot shared by the host bridge and the bus masters, a slot for the DMA channels, and a slot for memory refresh. The three slots take turns in a rotating order. Inside the shared slot, the host bridge and the bus masters (as one group) alternate. The bus masters take turns in their own ring of up to eight request lines. DMA channels are ranked by fixed priority or by rotating priority, chosen by a mode register.

A decision is made on every clock edge where the evaluate strobe is high. It is held on registered one-hot grant outputs, with a valid flag, until the next evaluation. A rotation pointer moves only when its own group wins. A group with no request is skipped and its pointer does not move. The mode register resets to fixed priority and changes only through a write strobe.

Top module: `hier_bus_arb`

## Requirements
- R1: After reset all grant outputs and `gnt_valid_o` are low, DMA ranking is fixed, and every pointer favours index 0: the shared slot first at the top level, the host bridge first within the shared slot, master 0 and DMA channel 0.
- R2: Grant outputs change only in the cycle after a clock edge where `eval_i` is high. They then reflect the requests sampled at that edge and hold unchanged until the next such edge.
- R3: At most one grant bit is set across host, master, DMA and refresh grants. `gnt_valid_o` is high exactly when one is set. An evaluation with at least one request always produces a grant, and an evaluation with none produces no grant.
- R4: A grant goes only to a requester whose request was high at the evaluating edge.
- R5: The top-level order is shared slot, then DMA, then refresh, then back to the shared slot. After slot p wins, the next slot in that order has the highest priority. Slots with no request are skipped, and the top pointer moves only when some slot is granted.
- R6: Within the shared slot, after the host bridge wins, the master group has priority. After a master wins, the host bridge has priority. This state changes only when the shared slot wins.
- R7: After master i is granted, master i+1 (wrapping to 0) has the highest priority among masters. The master pointer moves only on a master grant.
- R8: In fixed mode the DMA winner is the lowest-numbered requesting channel.
- R9: In rotating mode, after channel i wins, channel i+1 (wrapping) has the highest priority. The DMA pointer follows every DMA grant in either mode.
- R10: A cycle with `cfg_we_i` high loads `cfg_rot_i` into the mode register (1 means rotating). The new mode applies to evaluations in later cycles. With `cfg_we_i` low, `cfg_rot_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe; a decision is taken at this edge |
| host_req_i | input | 1 | Host bridge request |
| mst_req_i | input | NUM_MST | Bus master requests |
| dma_req_i | input | NUM_DMA | DMA channel requests |
| rfsh_req_i | input | 1 | Refresh request |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_rot_i | input | 1 | Mode value: 1 rotating, 0 fixed |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_host_o | output | 1 | Host bridge granted |
| gnt_mst_o | output | NUM_MST | One-hot master grant |
| gnt_dma_o | output | NUM_DMA | One-hot DMA channel grant |
| gnt_rfsh_o | output | 1 | Refresh granted |

## Verification
The properties assume that every request, strobe and mode input is a known 0 or 1 at each evaluating edge. They also assume that the mode seen by an evaluation is the one registered before that edge. The fixed-priority check therefore relies on mode writes landing in cycles of their own. The bench changes every input on the falling clock edge, which keeps inputs stable around the rising edge. It also issues mode writes only in cycles without an evaluation, so all stimulus stays within these assumptions.

// File: rtl/hba_pkg.sv
package hba_pkg;
   localparam int TOP_SLOTS = 3;
   localparam int SLOT_SHARED = 0;
   localparam int SLOT_DMA = 1;
   localparam int SLOT_RFSH = 2;
   localparam int SHARED_HOST = 0;
   localparam int SHARED_MST = 1;
endpackage

// File: rtl/hba_ring.sv
module hba_ring #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] taken,
   output logic [N-1:0] gnt,
   output logic         any
);
   localparam int W = (N > 1) ? $clog2(N) : 1;

   logic [W-1:0] ptr_q;
   logic [W-1:0] win;
   logic [W-1:0] tk_idx;
   logic [W:0]   cand;

   always_comb begin
      any  = 1'b0;
      win  = '0;
      cand = '0;
      for (int k = N - 1; k >= 0; k--) begin
         cand = {1'b0, ptr_q} + (W+1)'(k);
         if (cand >= (W+1)'(N)) cand = cand - (W+1)'(N);
         if (req[cand[W-1:0]]) begin
            any = 1'b1;
            win = cand[W-1:0];
         end
      end
      gnt = any ? (N'(1) << win) : '0;
   end

   always_comb begin
      tk_idx = '0;
      for (int i = 0; i < N; i++)
         if (taken[i]) tk_idx = W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (|taken)
         ptr_q <= (tk_idx == W'(N - 1)) ? '0 : tk_idx + 1'b1;
   end
endmodule

// File: rtl/hba_dma_rank.sv
module hba_dma_rank #(
   parameter int N      = 8,
   parameter bit ROT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] taken,
   input  logic         cfg_we,
   input  logic         cfg_rot,
   output logic [N-1:0] pick,
   output logic         any,
   output logic         rot_mode
);
   logic [N-1:0] fixed_pick;

   assign fixed_pick = req & (~req + 1'b1);
   assign any        = |req;

   generate
      if (ROT_EN) begin : g_rot
         logic         rot_q;
         logic [N-1:0] ring_gnt;
         logic         ring_any;

         always_ff @(posedge clk) begin
            if (!rst_n)
               rot_q <= 1'b0;
            else if (cfg_we)
               rot_q <= cfg_rot;
         end

         hba_ring #(.N(N)) u_ring (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req),
            .taken (taken),
            .gnt   (ring_gnt),
            .any   (ring_any)
         );

         logic unused_any;
         assign unused_any = ring_any;
         assign pick       = rot_q ? ring_gnt : fixed_pick;
         assign rot_mode   = rot_q;
      end else begin : g_fix
         logic unused_cfg;
         assign unused_cfg = ^{clk, rst_n, taken, cfg_we, cfg_rot};
         assign pick       = fixed_pick;
         assign rot_mode   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hier_bus_arb.sv
module hier_bus_arb
   import hba_pkg::*;
#(
   parameter int NUM_MST    = 8,
   parameter int NUM_DMA    = 8,
   parameter bit DMA_ROT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eval_i,
   input  logic               host_req_i,
   input  logic [NUM_MST-1:0] mst_req_i,
   input  logic [NUM_DMA-1:0] dma_req_i,
   input  logic               rfsh_req_i,
   input  logic               cfg_we_i,
   input  logic               cfg_rot_i,
   output logic               gnt_valid_o,
   output logic               gnt_host_o,
   output logic [NUM_MST-1:0] gnt_mst_o,
   output logic [NUM_DMA-1:0] gnt_dma_o,
   output logic               gnt_rfsh_o
);
   generate
      if (NUM_MST < 1 || NUM_MST > 8) begin : g_bad_mst
         $error("NUM_MST must lie in 1..8");
      end
      if (NUM_DMA < 1 || NUM_DMA > 8) begin : g_bad_dma
         $error("NUM_DMA must lie in 1..8");
      end
   endgenerate

   logic [TOP_SLOTS-1:0] top_req, top_gnt, top_tk;
   logic                 top_any;
   logic [1:0]           sh_req, sh_gnt, sh_tk;
   logic                 sh_any;
   logic [NUM_MST-1:0]   mst_gnt, mst_tk;
   logic                 mst_any;
   logic [NUM_DMA-1:0]   dma_pick, dma_tk;
   logic                 dma_any;
   logic                 dma_rot_mode;

   logic                 nx_host, nx_rfsh;
   logic [NUM_MST-1:0]   nx_mst;
   logic [NUM_DMA-1:0]   nx_dma;

   hba_ring #(.N(NUM_MST)) u_mst_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (mst_req_i),
      .taken (mst_tk),
      .gnt   (mst_gnt),
      .any   (mst_any)
   );

   hba_dma_rank #(.N(NUM_DMA), .ROT_EN(DMA_ROT_EN)) u_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (dma_req_i),
      .taken    (dma_tk),
      .cfg_we   (cfg_we_i),
      .cfg_rot  (cfg_rot_i),
      .pick     (dma_pick),
      .any      (dma_any),
      .rot_mode (dma_rot_mode)
   );

   assign sh_req[SHARED_HOST] = host_req_i;
   assign sh_req[SHARED_MST]  = mst_any;

   hba_ring #(.N(2)) u_shared (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (sh_req),
      .taken (sh_tk),
      .gnt   (sh_gnt),
      .any   (sh_any)
   );

   assign top_req[SLOT_SHARED] = sh_any;
   assign top_req[SLOT_DMA]    = dma_any;
   assign top_req[SLOT_RFSH]   = rfsh_req_i;

   hba_ring #(.N(TOP_SLOTS)) u_top (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (top_req),
      .taken (top_tk),
      .gnt   (top_gnt),
      .any   (top_any)
   );

   always_comb begin
      nx_host = top_gnt[SLOT_SHARED] & sh_gnt[SHARED_HOST];
      nx_mst  = (top_gnt[SLOT_SHARED] & sh_gnt[SHARED_MST]) ? mst_gnt : '0;
      nx_dma  = top_gnt[SLOT_DMA] ? dma_pick : '0;
      nx_rfsh = top_gnt[SLOT_RFSH];
      top_tk  = eval_i ? top_gnt : '0;
      sh_tk   = (eval_i && top_gnt[SLOT_SHARED]) ? sh_gnt : '0;
      mst_tk  = eval_i ? nx_mst : '0;
      dma_tk  = eval_i ? nx_dma : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_valid_o <= 1'b0;
         gnt_host_o  <= 1'b0;
         gnt_mst_o   <= '0;
         gnt_dma_o   <= '0;
         gnt_rfsh_o  <= 1'b0;
      end else if (eval_i) begin
         gnt_valid_o <= top_any;
         gnt_host_o  <= nx_host;
         gnt_mst_o   <= nx_mst;
         gnt_dma_o   <= nx_dma;
         gnt_rfsh_o  <= nx_rfsh;
      end
   end
endmodule

// File: rtl/hba_chk.sv
module hba_chk #(
   parameter int NUM_MST = 8,
   parameter int NUM_DMA = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               eval_i,
   input logic               host_req_i,
   input logic [NUM_MST-1:0] mst_req_i,
   input logic [NUM_DMA-1:0] dma_req_i,
   input logic               rfsh_req_i,
   input logic               gnt_valid_o,
   input logic               gnt_host_o,
   input logic [NUM_MST-1:0] gnt_mst_o,
   input logic [NUM_DMA-1:0] gnt_dma_o,
   input logic               gnt_rfsh_o,
   input logic               dma_rot
);
   localparam int VW = NUM_MST + NUM_DMA + 2;

   logic [VW-1:0]      gv, rv;
   logic [NUM_DMA-1:0] dreq_q, dlow;

   assign gv = {gnt_rfsh_o, gnt_dma_o, gnt_mst_o, gnt_host_o};
   assign rv = {rfsh_req_i, dma_req_i, mst_req_i, host_req_i};

   always_ff @(posedge clk) dreq_q <= dma_req_i;
   assign dlow = dreq_q & (~dreq_q + 1'b1);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv)); // R3
   AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid_o == (gv != '0)); // R3
   AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_i |=> $stable(gv)); // R2
   AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      eval_i |=> ((gv & ~$past(rv)) == '0)); // R4
   AST_GRANT_IF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && rv != '0) |=> gnt_valid_o); // R3
   AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && rv == '0) |=> !gnt_valid_o); // R3
   AST_DMA_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && !dma_rot) |=> (gnt_dma_o == '0 || gnt_dma_o == dlow)); // R8
endmodule

bind hier_bus_arb hba_chk #(.NUM_MST(NUM_MST), .NUM_DMA(NUM_DMA)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .eval_i      (eval_i),
   .host_req_i  (host_req_i),
   .mst_req_i   (mst_req_i),
   .dma_req_i   (dma_req_i),
   .rfsh_req_i  (rfsh_req_i),
   .gnt_valid_o (gnt_valid_o),
   .gnt_host_o  (gnt_host_o),
   .gnt_mst_o   (gnt_mst_o),
   .gnt_dma_o   (gnt_dma_o),
   .gnt_rfsh_o  (gnt_rfsh_o),
   .dma_rot     (dma_rot_mode)
);

// File: tb/test_hier_bus_arb.sv
`timescale 1ns/1ps
module test_hier_bus_arb;
   localparam int NM = 4;
   localparam int ND = 4;
   localparam int VW = NM + ND + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eval_i = 1'b0, host_req_i = 1'b0, rfsh_req_i = 1'b0;
   logic cfg_we_i = 1'b0, cfg_rot_i = 1'b0;
   logic [NM-1:0] mst_req_i = '0;
   logic [ND-1:0] dma_req_i = '0;
   logic gnt_valid_o, gnt_host_o, gnt_rfsh_o;
   logic [NM-1:0] gnt_mst_o;
   logic [ND-1:0] gnt_dma_o;

   always #4 clk = ~clk;

   hier_bus_arb #(.NUM_MST(NM), .NUM_DMA(ND)) i_hier_bus_arb (
      .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .host_req_i(host_req_i),
      .mst_req_i(mst_req_i), .dma_req_i(dma_req_i), .rfsh_req_i(rfsh_req_i),
      .cfg_we_i(cfg_we_i), .cfg_rot_i(cfg_rot_i), .gnt_valid_o(gnt_valid_o),
      .gnt_host_o(gnt_host_o), .gnt_mst_o(gnt_mst_o), .gnt_dma_o(gnt_dma_o),
      .gnt_rfsh_o(gnt_rfsh_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int m_top = 0, m_sh = 0, m_mst = 0, m_dma = 0;
   bit m_rot = 1'b0;
   logic [VW-1:0] last_exp = '0;

   function automatic logic [VW-1:0] act_vec();
      return {gnt_rfsh_o, gnt_dma_o, gnt_mst_o, gnt_host_o};
   endfunction

   function automatic int pick(input logic [7:0] r, input int n, input int p);
      for (int k = 0; k < n; k++) begin
         int q = (p + k) % n;
         if (r[q]) return q;
      end
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input logic [VW-1:0] a,
                        input logic [VW-1:0] e);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, a, e);
      end
   endtask

   task automatic do_eval(input logic h, input logic [NM-1:0] m, input logic [ND-1:0] d,
                          input logic f, input string tag_in);
      logic [VW-1:0] e;
      string tag;
      int t, s, i;
      e = '0;
      tag = "R3";
      t = pick({5'b0, f, |d, h | (|m)}, 3, m_top);
      if (t == 0) begin
         s = pick({6'b0, |m, h}, 2, m_sh);
         m_sh = (s + 1) % 2;
         if (s == 0) begin
            e[0] = 1'b1; tag = "R6";
         end else begin
            i = pick({4'b0, m}, NM, m_mst);
            e[1 + i] = 1'b1; m_mst = (i + 1) % NM; tag = "R7";
         end
      end else if (t == 1) begin
         i = pick({4'b0, d}, ND, m_rot ? m_dma : 0);
         e[1 + NM + i] = 1'b1; m_dma = (i + 1) % ND;
         tag = m_rot ? "R9" : "R8";
      end else if (t == 2) begin
         e[VW-1] = 1'b1; tag = "R5";
      end
      if (t >= 0) m_top = (t + 1) % 3;
      if (tag_in != "") tag = tag_in;
      host_req_i = h; mst_req_i = m; dma_req_i = d; rfsh_req_i = f; eval_i = 1'b1;
      @(negedge clk);
      eval_i = 1'b0;
      check(act_vec() == e, tag, act_vec(), e);
      check(gnt_valid_o == (e != '0), "R3", {9'b0, gnt_valid_o}, {9'b0, e != '0});
      last_exp = e;
   endtask

   task automatic write_mode(input logic we, input logic rot);
      cfg_we_i = we; cfg_rot_i = rot;
      @(negedge clk);
      cfg_we_i = 1'b0; cfg_rot_i = 1'b0;
      if (we) m_rot = rot;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(act_vec() == '0 && !gnt_valid_o, "R1", act_vec(), '0);
      // R3: evaluation with no request
      do_eval(1'b0, '0, '0, 1'b0, "R3");
      // R1 R5: full load, first winner is the host bridge, then rotation order
      do_eval(1'b1, '1, '1, 1'b1, "R1");
      for (int k = 0; k < 11; k++) do_eval(1'b1, '1, '1, 1'b1, "R5");
      // R2: outputs hold without eval while requests change
      host_req_i = 1'b0; mst_req_i = '1; dma_req_i = 4'b1010; rfsh_req_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(act_vec() == last_exp, "R2", act_vec(), last_exp);
      end
      // R5: empty positions skipped (only refresh, then only DMA)
      do_eval(1'b0, '0, '0, 1'b1, "R5");
      do_eval(1'b0, '0, 4'b0100, 1'b0, "R5");
      // R10: cfg_rot without write strobe leaves fixed mode
      write_mode(1'b0, 1'b1);
      do_eval(1'b0, '0, 4'b0110, 1'b0, "R10");
      do_eval(1'b0, '0, 4'b0110, 1'b0, "R10");
      // sweep all request patterns in fixed mode
      for (int v = 0; v < 1024; v++) begin
         logic [9:0] p = 10'((v * 397) % 1024);
         do_eval(p[0], p[4:1], p[8:5], p[9], "");
      end
      // R10: write rotating mode
      write_mode(1'b1, 1'b1);
      do_eval(1'b0, '0, 4'b0110, 1'b0, "R10");
      do_eval(1'b0, '0, 4'b0110, 1'b0, "R10");
      for (int v = 0; v < 1024; v++) begin
         logic [9:0] p = 10'((v * 661 + 5) % 1024);
         do_eval(p[0], p[4:1], p[8:5], p[9], "");
      end
      // R10: return to fixed mode
      write_mode(1'b1, 1'b0);
      do_eval(1'b0, '0, 4'b1100, 1'b0, "R10");
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule